// File: doc/BRIEF.md
# Pipeline Operand Forwarding and Load-Use Stall Controller

This block holds the hazard control of a five-stage in-order pipeline. Every cycle it looks at the two source register numbers of the instruction in the execute stage. It compares them with the destination registers and write enables held in the two later pipeline registers: the one after execute (EX/MEM) and the one after memory (MEM/WB). For each ALU operand it drives a 2-bit select that tells the operand multiplexer where to take the value from: the register file, the EX/MEM result or the MEM/WB result. The younger result wins when both later stages match.

The block also looks for a load-use hazard. This is a load in ID/EX whose target register is read by the instruction waiting in IF/ID. When it finds one, it holds the program counter and the IF/ID register for one cycle. In the same cycle it replaces the decoded control word entering ID/EX with all zeros, which inserts a bubble. A two-state controller makes sure a stall lasts exactly one cycle:

- ST_FLOW is the normal state. Transition T_DETECT leaves ST_FLOW for ST_BUBBLE when a hazard is seen. Transition T_IDLE keeps ST_FLOW when there is no hazard.
- ST_BUBBLE is the cycle after a stall. Transition T_RELEASE always returns to ST_FLOW, and the block raises no stall while in ST_BUBBLE.

After the bubble, the loaded value reaches the dependent instruction through MEM/WB forwarding. All outputs are combinational from the current inputs and the controller state.

Top module: `hz_forward_unit`

## Requirements
- R1: When the EX/MEM write enable is 1, its destination is nonzero and it equals an execute-stage source register, that operand's select is 2'b10.
- R2: When R1 does not hold for an operand, but the MEM/WB write enable is 1, its destination is nonzero and it equals that source register, the select is 2'b01.
- R3: When both EX/MEM and MEM/WB qualify for the same operand, the select is 2'b10.
- R4: A source register of 0 always gets select 2'b00, even if a writing instruction targets register 0.
- R5: In every other case the select is 2'b00 (register file). Operand A uses the execute-stage Rs and operand B the execute-stage Rt.
- R6: In ST_FLOW, pc_hold_o and ifid_hold_o are both 1 exactly when the ID/EX memory-read flag is 1 and the ID/EX Rt equals the IF/ID Rs or the IF/ID Rt.
- R7: The control word output is all zeros while a stall is raised. Otherwise it equals the decoded control word input. The bit layout is [8] dest-select, [7:6] ALU op, [5] ALU source, [4] branch, [3] memory read, [2] memory write, [1] memory-to-register, [0] register write.
- R8: A stall lasts exactly one cycle. In the cycle after a stall, no stall is raised even if the hazard condition still holds. The cycle after that, a stall may be raised again.
- R9: After reset the controller is in ST_FLOW. With all inputs at zero, both selects are 2'b00, no stall is raised and the control word output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ex_rs_i | input | REG_W | Execute-stage source register Rs |
| ex_rt_i | input | REG_W | Execute-stage source register Rt |
| exm_rd_i | input | REG_W | EX/MEM destination register |
| exm_wr_i | input | 1 | EX/MEM register write enable |
| mwb_rd_i | input | REG_W | MEM/WB destination register |
| mwb_wr_i | input | 1 | MEM/WB register write enable |
| idex_memrd_i | input | 1 | ID/EX memory-read flag |
| idex_rt_i | input | REG_W | ID/EX Rt (load target) |
| ifid_rs_i | input | REG_W | IF/ID source register Rs |
| ifid_rt_i | input | REG_W | IF/ID source register Rt |
| dec_ctrl_i | input | CTRL_W | Decoded control word bound for ID/EX |
| fwd_a_o | output | 2 | Operand A forwarding select |
| fwd_b_o | output | 2 | Operand B forwarding select |
| pc_hold_o | output | 1 | Hold the program counter |
| ifid_hold_o | output | 1 | Hold the IF/ID register |
| idex_ctrl_o | output | CTRL_W | Control word written into ID/EX |

## Verification
The bench builds the block with REG_W set to 3, so there are only eight register numbers. With that few, random register fields collide often. The collisions create EX/MEM and MEM/WB matches, double matches that exercise priority, register-0 writers, and load-use hits without any directed steering. Directed sequences add back-to-back dependencies, a load-use hazard that persists across the bubble cycle, and a re-stall two cycles later, all checked against a bench model of the two-state controller.

// File: rtl/hazard_pkg.sv
package hazard_pkg;
    typedef enum logic [0:0] {
        ST_FLOW   = 1'b0,
        ST_BUBBLE = 1'b1
    } hz_state_e;

    localparam logic [1:0] SEL_REGFILE = 2'b00;
    localparam logic [1:0] SEL_EXMEM   = 2'b10;
    localparam logic [1:0] SEL_MEMWB   = 2'b01;

    localparam int DEF_REG_W  = 5;
    localparam int DEF_CTRL_W = 9;
endpackage

// File: rtl/hz_operand_sel.sv
module hz_operand_sel
    import hazard_pkg::*;
#(
    parameter int REG_W = DEF_REG_W
) (
    input  logic [REG_W-1:0] src_i,
    input  logic [REG_W-1:0] exm_rd_i,
    input  logic             exm_wr_i,
    input  logic [REG_W-1:0] mwb_rd_i,
    input  logic             mwb_wr_i,
    output logic [1:0]       sel_o
);
    localparam logic [REG_W-1:0] ZERO_REG = '0;

    logic exm_hit;
    logic mwb_hit;

    always_comb begin
        exm_hit = exm_wr_i && (exm_rd_i != ZERO_REG) && (exm_rd_i == src_i);
        mwb_hit = mwb_wr_i && (mwb_rd_i != ZERO_REG) && (mwb_rd_i == src_i);
    end

    // Younger result (EX/MEM) takes priority over MEM/WB.
    always_comb begin
        if (exm_hit)      sel_o = SEL_EXMEM;
        else if (mwb_hit) sel_o = SEL_MEMWB;
        else              sel_o = SEL_REGFILE;
    end
endmodule

// File: rtl/hz_loaduse_det.sv
module hz_loaduse_det
    import hazard_pkg::*;
#(
    parameter int REG_W = DEF_REG_W
) (
    input  logic             idex_memrd_i,
    input  logic [REG_W-1:0] idex_rt_i,
    input  logic [REG_W-1:0] ifid_rs_i,
    input  logic [REG_W-1:0] ifid_rt_i,
    output logic             hazard_o
);
    logic rs_dep;
    logic rt_dep;

    always_comb begin
        rs_dep   = (idex_rt_i == ifid_rs_i);
        rt_dep   = (idex_rt_i == ifid_rt_i);
        hazard_o = idex_memrd_i && (rs_dep || rt_dep);
    end
endmodule

// File: rtl/hz_stall_fsm.sv
module hz_stall_fsm
    import hazard_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hazard_i,
    output logic stall_o
);
    hz_state_e state_q;
    hz_state_e state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_FLOW;
        else        state_q <= state_d;
    end

    // Next state and output
    always_comb begin
        state_d = state_q;
        stall_o = 1'b0;
        unique case (state_q)
            ST_FLOW: begin
                if (hazard_i) begin      // T_DETECT
                    stall_o = 1'b1;
                    state_d = ST_BUBBLE;
                end else begin           // T_IDLE
                    state_d = ST_FLOW;
                end
            end
            ST_BUBBLE: begin             // T_RELEASE
                stall_o = 1'b0;
                state_d = ST_FLOW;
            end
            default: begin
                state_d = ST_FLOW;
            end
        endcase
    end

    // R8: never two stall cycles in a row
    p_single_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stall_o |=> !stall_o)
        else $error("p_single_stall_r8");

    // R6: a hazard seen in ST_FLOW always stalls
    p_detect_stalls_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FLOW && hazard_i) |-> stall_o)
        else $error("p_detect_stalls_r6");
endmodule

// File: rtl/hz_forward_unit.sv
module hz_forward_unit
    import hazard_pkg::*;
#(
    parameter int REG_W  = DEF_REG_W,
    parameter int CTRL_W = DEF_CTRL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_W-1:0]  ex_rs_i,
    input  logic [REG_W-1:0]  ex_rt_i,
    input  logic [REG_W-1:0]  exm_rd_i,
    input  logic              exm_wr_i,
    input  logic [REG_W-1:0]  mwb_rd_i,
    input  logic              mwb_wr_i,
    input  logic              idex_memrd_i,
    input  logic [REG_W-1:0]  idex_rt_i,
    input  logic [REG_W-1:0]  ifid_rs_i,
    input  logic [REG_W-1:0]  ifid_rt_i,
    input  logic [CTRL_W-1:0] dec_ctrl_i,
    output logic [1:0]        fwd_a_o,
    output logic [1:0]        fwd_b_o,
    output logic              pc_hold_o,
    output logic              ifid_hold_o,
    output logic [CTRL_W-1:0] idex_ctrl_o
);
    localparam int N_OPS = 2;

    logic [REG_W-1:0] src_arr [N_OPS];
    logic [1:0]       sel_arr [N_OPS];
    logic             hazard;
    logic             stall;

    assign src_arr[0] = ex_rs_i;
    assign src_arr[1] = ex_rt_i;

    for (genvar g = 0; g < N_OPS; g++) begin : g_op
        hz_operand_sel #(.REG_W(REG_W)) u_sel (
            .src_i    (src_arr[g]),
            .exm_rd_i (exm_rd_i),
            .exm_wr_i (exm_wr_i),
            .mwb_rd_i (mwb_rd_i),
            .mwb_wr_i (mwb_wr_i),
            .sel_o    (sel_arr[g])
        );
    end

    assign fwd_a_o = sel_arr[0];
    assign fwd_b_o = sel_arr[1];

    hz_loaduse_det #(.REG_W(REG_W)) u_det (
        .idex_memrd_i (idex_memrd_i),
        .idex_rt_i    (idex_rt_i),
        .ifid_rs_i    (ifid_rs_i),
        .ifid_rt_i    (ifid_rt_i),
        .hazard_o     (hazard)
    );

    hz_stall_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .hazard_i (hazard),
        .stall_o  (stall)
    );

    always_comb begin
        pc_hold_o   = stall;
        ifid_hold_o = stall;
        idex_ctrl_o = stall ? '0 : dec_ctrl_i;
    end

    // R1: qualified EX/MEM match selects EX/MEM for operand A
    p_exm_fwd_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (exm_wr_i && exm_rd_i != '0 && exm_rd_i == ex_rs_i) |-> fwd_a_o == 2'b10)
        else $error("p_exm_fwd_r1");

    // R2: MEM/WB used for operand B only without an EX/MEM match
    p_mwb_fwd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_b_o == 2'b01) |-> (mwb_wr_i && mwb_rd_i == ex_rt_i &&
                                !(exm_wr_i && exm_rd_i == ex_rt_i)))
        else $error("p_mwb_fwd_r2");

    // R4: register 0 is never forwarded
    p_zero_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_rs_i == '0) |-> fwd_a_o == 2'b00)
        else $error("p_zero_src_r4");

    // R7: a bubble carries no control
    p_bubble_ctrl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pc_hold_o |-> (idex_ctrl_o == '0 && ifid_hold_o))
        else $error("p_bubble_ctrl_r7");
endmodule

// File: tb/hz_forward_unit_bench.sv
module hz_forward_unit_bench;
    localparam int CLK_PERIOD = 10;
    localparam int RW = 3;
    localparam int CW = 9;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [RW-1:0] ex_rs, ex_rt, exm_rd, mwb_rd, idex_rt, ifid_rs, ifid_rt;
    logic          exm_wr, mwb_wr, idex_memrd;
    logic [CW-1:0] dec_ctrl;
    logic [1:0]    fwd_a, fwd_b;
    logic          pc_hold, ifid_hold;
    logic [CW-1:0] idex_ctrl;

    int n_chk = 0;
    int n_bad = 0;
    bit model_bubble = 1'b0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hz_forward_unit #(.REG_W(RW), .CTRL_W(CW)) u_hz_forward_unit (
        .clk(clk), .rst_n(rst_n),
        .ex_rs_i(ex_rs), .ex_rt_i(ex_rt),
        .exm_rd_i(exm_rd), .exm_wr_i(exm_wr),
        .mwb_rd_i(mwb_rd), .mwb_wr_i(mwb_wr),
        .idex_memrd_i(idex_memrd), .idex_rt_i(idex_rt),
        .ifid_rs_i(ifid_rs), .ifid_rt_i(ifid_rt),
        .dec_ctrl_i(dec_ctrl),
        .fwd_a_o(fwd_a), .fwd_b_o(fwd_b),
        .pc_hold_o(pc_hold), .ifid_hold_o(ifid_hold),
        .idex_ctrl_o(idex_ctrl)
    );

    function automatic logic [1:0] ref_sel(input logic [RW-1:0] s);
        if (exm_wr && exm_rd != 0 && exm_rd == s) return 2'b10;
        if (mwb_wr && mwb_rd != 0 && mwb_rd == s) return 2'b01;
        return 2'b00;
    endfunction

    function automatic string sel_tag(input logic [RW-1:0] s);
        bit e = exm_wr && exm_rd != 0 && exm_rd == s;
        bit m = mwb_wr && mwb_rd != 0 && mwb_rd == s;
        if (s == 0)  return "R4";
        if (e && m)  return "R3";
        if (e)       return "R1";
        if (m)       return "R2";
        return "R5";
    endfunction

    function automatic bit ref_hazard();
        return idex_memrd && (idex_rt == ifid_rs || idex_rt == ifid_rt);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Checks at the current inputs; updates the bench controller model.
    task automatic check_all(input string stag);
        bit exp_stall = !model_bubble && ref_hazard();
        string ht = model_bubble ? "R8" : "R6";
        chk({sel_tag(ex_rs), " fwd_a"}, fwd_a, ref_sel(ex_rs));
        chk({sel_tag(ex_rt), " fwd_b"}, fwd_b, ref_sel(ex_rt));
        chk({ht, " pc_hold ", stag}, pc_hold, exp_stall);
        chk({ht, " ifid_hold ", stag}, ifid_hold, exp_stall);
        chk({"R7 ctrl ", stag}, idex_ctrl, exp_stall ? 0 : dec_ctrl);
        model_bubble = exp_stall;
    endtask

    task automatic cycle(input string stag);
        #(CLK_PERIOD - 2);
        check_all(stag);
        @(posedge clk);
        #1;
    endtask

    task automatic clear_in();
        ex_rs = 0; ex_rt = 0; exm_rd = 0; mwb_rd = 0; idex_rt = 0;
        ifid_rs = 0; ifid_rt = 0; exm_wr = 0; mwb_wr = 0; idex_memrd = 0;
        dec_ctrl = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        clear_in();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;

        // R9: reset state
        #(CLK_PERIOD - 2);
        chk("R9 fwd_a", fwd_a, 0);
        chk("R9 fwd_b", fwd_b, 0);
        chk("R9 pc_hold", pc_hold, 0);
        chk("R9 idex_ctrl", idex_ctrl, 0);
        @(posedge clk); #1;

        // R1 / R2 back-to-back dependency
        dec_ctrl = 9'h1A5;
        exm_wr = 1; exm_rd = 3; mwb_wr = 1; mwb_rd = 5;
        ex_rs = 3; ex_rt = 5;
        cycle("dep");
        // R3: both stages write the same register
        mwb_rd = 3; ex_rt = 3;
        cycle("prio");
        // R4: register 0 writers
        exm_rd = 0; mwb_rd = 0; ex_rs = 0; ex_rt = 0;
        cycle("zero");
        #(CLK_PERIOD - 2);
        chk("R4 fwd_a zero dest", fwd_a, 0);
        @(posedge clk); #1;
        // R5: writes disabled
        exm_wr = 0; mwb_wr = 0; exm_rd = 2; mwb_rd = 2; ex_rs = 2; ex_rt = 2;
        cycle("nowr");

        // R6 / R8: persistent load-use hazard
        idex_memrd = 1; idex_rt = 4; ifid_rs = 4; ifid_rt = 1; dec_ctrl = 9'h1FF;
        #(CLK_PERIOD - 2);
        chk("R6 stall raised", pc_hold, 1);
        chk("R7 ctrl zeroed", idex_ctrl, 0);
        check_all("lu1");
        @(posedge clk); #1;
        #(CLK_PERIOD - 2);
        chk("R8 no second stall", pc_hold, 0);
        chk("R8 ctrl passes", idex_ctrl, 9'h1FF);
        check_all("lu2");
        @(posedge clk); #1;
        ifid_rs = 0; ifid_rt = 4;
        #(CLK_PERIOD - 2);
        chk("R8 re-stall allowed", pc_hold, 1);
        check_all("lu3");
        @(posedge clk); #1;
        idex_memrd = 0;
        cycle("lu4");
        // R6: Rt match without memory read does not stall
        idex_rt = 6; ifid_rs = 6;
        cycle("nomr");

        // Random mix
        for (int i = 0; i < 400; i++) begin
            ex_rs = RW'($urandom_range(0, 7)); ex_rt = RW'($urandom_range(0, 7));
            exm_rd = RW'($urandom_range(0, 7)); mwb_rd = RW'($urandom_range(0, 7));
            exm_wr = 1'($urandom_range(0, 1)); mwb_wr = 1'($urandom_range(0, 1));
            idex_memrd = 1'($urandom_range(0, 1));
            idex_rt = RW'($urandom_range(0, 7));
            ifid_rs = RW'($urandom_range(0, 7)); ifid_rt = RW'($urandom_range(0, 7));
            dec_ctrl = CW'($urandom);
            cycle("rand");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule